// File: doc/BRIEF.md
# VLIW Packet Sequencer

This block walks a processor front end through one very-long-instruction-word packet at a time. Starting from a packet address, it reads consecutive 32-bit instruction words from instruction memory, one per request. Before each word goes to the execute stage, it clears general register 0. It then offers the word, its address and first/last markers on a valid/ready issue port. A word whose top bit is set closes the packet. If no word closes it, the packet closes once a parameterised number of words has issued.

Every packet opens with a one-cycle pulse that resets the parallel write queue. It closes with a commit request, which covers the queued write-back and the interrupt check. The block then waits for the commit to complete and takes the address of the next packet from the commit response. When a packet closes, a retired-instruction total is increased by that packet's instruction count. The block also keeps track of the most recent floating/media slot used by an issued instruction in the current packet.

Top module: `vliw_packet_sequencer`

## Requirements
- R1: Within a packet, words are fetched from the packet address and then at steps of +4 bytes. Each word is presented on `iss_word` together with its own address on `iss_pc`.
- R2: A word with bit 31 set (mask 0x80000000) is the last of its packet. It is issued with `iss_last` high, and no further word is fetched before the commit.
- R3: When no word closes the packet, it ends after MAX_SLOTS words (default 8), and the word in the final slot carries `iss_last`.
- R4: `iss_first` is high for the first issued word of a packet and low for every later word.
- R5: `gr0_clr` pulses for exactly one cycle before every issue, so each packet has as many pulses as it has issued words.
- R6: `wq_init` pulses exactly once per packet, before the first fetch of that packet.
- R7: After the handshake of the last word, `commit_start` pulses once. When `commit_done` arrives, the next packet starts at `commit_pc`.
- R8: `retired` increases by the packet's instruction count, and the new value is visible by the cycle in which `commit_start` is high.
- R9: An issue accepted with `iss_slot` in 4..7 records media slot `iss_slot[1:0]` (`media_vld`=1, `media_id`), and the latest such issue wins. Codes 0..3 leave the record unchanged. The record is cleared at each packet start.
- R10: While `iss_valid` is high and `iss_ready` is low, `iss_valid`, `iss_word` and `iss_pc` hold steady.
- R11: While reset is asserted, `retired` is 0 and `iss_valid`, `commit_start` and `imem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Instruction read request, held until data returns |
| imem_addr | output | 32 | Byte address of the requested word |
| imem_rvalid | input | 1 | Read data valid |
| imem_rdata | input | 32 | Read instruction word |
| gr0_clr | output | 1 | Write zero to general register 0 |
| wq_init | output | 1 | Reset the parallel write queue (packet start) |
| iss_valid | output | 1 | Instruction offered to execute stage |
| iss_ready | input | 1 | Execute stage accepts the instruction |
| iss_word | output | 32 | Instruction word |
| iss_pc | output | 32 | Address of the instruction |
| iss_first | output | 1 | First instruction of the packet |
| iss_last | output | 1 | Last instruction of the packet |
| iss_slot | input | 3 | Slot taken by the issued instruction; 4..7 are media slots 0..3 |
| media_vld | output | 1 | A media slot was used in this packet |
| media_id | output | 2 | Most recent media slot used |
| commit_start | output | 1 | Start write-back and interrupt check |
| commit_done | input | 1 | Commit finished |
| commit_pc | input | 32 | Start address of the next packet |
| retired | output | RET_W | Retired-instruction total |

## Verification
Packets are run in several shapes: closed by the end bit after three words, closed by the end bit on the very first word, closed by the end bit exactly in the final slot, and carrying no end bit across ten words. Together these separate the end-bit rule from the size limit, and they show that the two agree when they fall on the same slot. One packet runs with read latency and a choppy ready. Matching its issued sequence against the zero-latency runs shows that stalls neither drop nor repeat words. A packet that uses two media slots, followed by a packet that uses none, shows that the latest slot wins and that the record is cleared at the next packet start.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned END_BIT = 31;
    localparam int unsigned STEP_B  = 4;

    typedef enum logic [2:0] {
        S_INIT,
        S_REQ,
        S_ZERO,
        S_ISSUE,
        S_COMMIT,
        S_WAIT
    } seq_state_e;

    typedef struct packed {
        logic       vld;
        logic [1:0] id;
    } media_rec_t;

    function automatic logic word_closes(input logic [WORD_W-1:0] w);
        return w[END_BIT];
    endfunction

    function automatic logic slot_is_media(input logic [2:0] s);
        return s[2];
    endfunction

endpackage

// File: rtl/pkt_seq_ctrl.sv
module pkt_seq_ctrl
    import pkt_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic imem_rvalid,
    input  logic iss_ready,
    input  logic pkt_last,
    input  logic commit_done,
    output logic wq_init,
    output logic imem_req,
    output logic latch_word,
    output logic gr0_clr,
    output logic iss_valid,
    output logic step,
    output logic finish,
    output logic commit_start,
    output logic load_pc
);

    seq_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_INIT;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d         = st_q;
        wq_init      = 1'b0;
        imem_req     = 1'b0;
        latch_word   = 1'b0;
        gr0_clr      = 1'b0;
        iss_valid    = 1'b0;
        step         = 1'b0;
        finish       = 1'b0;
        commit_start = 1'b0;
        load_pc      = 1'b0;
        case (st_q)
            S_INIT: begin
                wq_init = ~rst;
                st_d    = S_REQ;
            end
            S_REQ: begin
                imem_req = 1'b1;
                if (imem_rvalid) begin
                    latch_word = 1'b1;
                    st_d       = S_ZERO;
                end
            end
            S_ZERO: begin
                gr0_clr = 1'b1;
                st_d    = S_ISSUE;
            end
            S_ISSUE: begin
                iss_valid = 1'b1;
                if (iss_ready) begin
                    if (pkt_last) begin
                        finish = 1'b1;
                        st_d   = S_COMMIT;
                    end else begin
                        step = 1'b1;
                        st_d = S_REQ;
                    end
                end
            end
            S_COMMIT: begin
                commit_start = 1'b1;
                st_d         = S_WAIT;
            end
            S_WAIT: begin
                if (commit_done) begin
                    load_pc = 1'b1;
                    st_d    = S_INIT;
                end
            end
            default: st_d = S_INIT;
        endcase
    end

    // R6: a packet start is followed directly by a fetch request
    a_r6_init_then_fetch: assert property (@(posedge clk) disable iff (rst)
        wq_init |=> imem_req);

endmodule

// File: rtl/pkt_seq_count.sv
module pkt_seq_count #(
    parameter int unsigned MAX_SLOTS = 8,
    parameter int unsigned RET_W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic             finish,
    input  logic             word_end,
    output logic             is_first,
    output logic             is_last,
    output logic [RET_W-1:0] retired
);

    localparam int unsigned IDX_W = $clog2(MAX_SLOTS + 1);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAX_SLOTS - 1);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clr)  idx_q <= '0;
        else if (step)   idx_q <= idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)         retired <= '0;
        else if (finish) retired <= retired + RET_W'(idx_q) + RET_W'(1);
    end

    assign is_first = (idx_q == '0);
    assign is_last  = word_end || (idx_q == IDX_TOP);

    // R3: slot index never passes the packet size
    a_r3_idx_bound: assert property (@(posedge clk) disable iff (rst)
        step |-> idx_q < IDX_TOP);

    // R8: closing a packet moves the retired total
    a_r8_retire_moves: assert property (@(posedge clk) disable iff (rst)
        finish |=> retired != $past(retired));

endmodule

// File: rtl/pkt_seq_media.sv
module pkt_seq_media
    import pkt_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       take,
    input  logic [2:0] slot,
    output media_rec_t rec
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            rec <= '0;
        else if (take && slot_is_media(slot))
            rec <= '{vld: 1'b1, id: slot[1:0]};
    end

    // R9: the record only gains an entry through a media issue
    a_r9_media_source: assert property (@(posedge clk) disable iff (rst)
        (!take && !clr) |=> $stable(rec));

endmodule

// File: rtl/vliw_packet_sequencer.sv
module vliw_packet_sequencer
    import pkt_seq_pkg::*;
#(
    parameter int unsigned MAX_SLOTS = 8,
    parameter int unsigned RET_W     = 32,
    parameter logic [31:0] RESET_PC  = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    output logic             imem_req,
    output logic [31:0]      imem_addr,
    input  logic             imem_rvalid,
    input  logic [31:0]      imem_rdata,
    output logic             gr0_clr,
    output logic             wq_init,
    output logic             iss_valid,
    input  logic             iss_ready,
    output logic [31:0]      iss_word,
    output logic [31:0]      iss_pc,
    output logic             iss_first,
    output logic             iss_last,
    input  logic [2:0]       iss_slot,
    output logic             media_vld,
    output logic [1:0]       media_id,
    output logic             commit_start,
    input  logic             commit_done,
    input  logic [31:0]      commit_pc,
    output logic [RET_W-1:0] retired
);

    logic [31:0] pc_q;
    logic [31:0] word_q;
    logic        latch_word, step, finish, load_pc;
    media_rec_t  rec;

    pkt_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .imem_rvalid  (imem_rvalid),
        .iss_ready    (iss_ready),
        .pkt_last     (iss_last),
        .commit_done  (commit_done),
        .wq_init      (wq_init),
        .imem_req     (imem_req),
        .latch_word   (latch_word),
        .gr0_clr      (gr0_clr),
        .iss_valid    (iss_valid),
        .step         (step),
        .finish       (finish),
        .commit_start (commit_start),
        .load_pc      (load_pc)
    );

    pkt_seq_count #(
        .MAX_SLOTS (MAX_SLOTS),
        .RET_W     (RET_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .clr      (wq_init),
        .step     (step),
        .finish   (finish),
        .word_end (word_closes(word_q)),
        .is_first (iss_first),
        .is_last  (iss_last),
        .retired  (retired)
    );

    pkt_seq_media u_media (
        .clk  (clk),
        .rst  (rst),
        .clr  (wq_init),
        .take (iss_valid && iss_ready),
        .slot (iss_slot),
        .rec  (rec)
    );

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= RESET_PC;
        else if (load_pc) pc_q <= commit_pc;
        else if (step)    pc_q <= pc_q + STEP_B;
    end

    always_ff @(posedge clk) begin
        if (rst)             word_q <= '0;
        else if (latch_word) word_q <= imem_rdata;
    end

    assign imem_addr = pc_q;
    assign iss_word  = word_q;
    assign iss_pc    = pc_q;
    assign media_vld = rec.vld;
    assign media_id  = rec.id;

    // R5: every offer is preceded by a register-zero pulse
    a_r5_gr0_before_issue: assert property (@(posedge clk) disable iff (rst)
        $rose(iss_valid) |-> $past(gr0_clr));

    // R10: a stalled offer holds still
    a_r10_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=> iss_valid && $stable(iss_word) && $stable(iss_pc));

    // R7: commit request only right after the last handshake
    a_r7_commit_after_last: assert property (@(posedge clk) disable iff (rst)
        commit_start |-> $past(iss_valid && iss_ready && iss_last));

    // R9: the first offer of a packet sees a cleared media record
    a_r9_media_clear_first: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_first) |-> !media_vld);

endmodule

// File: tb/test_vliw_packet_sequencer.sv
module test_vliw_packet_sequencer;

    localparam int MAXP = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        imem_req, imem_rvalid;
    logic [31:0] imem_addr, imem_rdata;
    logic        gr0_clr, wq_init, iss_valid, iss_ready, iss_first, iss_last;
    logic [31:0] iss_word, iss_pc;
    logic [2:0]  iss_slot;
    logic        media_vld, commit_start, commit_done;
    logic [1:0]  media_id;
    logic [31:0] commit_pc, retired;

    always #10 clk = ~clk;

    vliw_packet_sequencer #(.MAX_SLOTS(MAXP)) i_vliw_packet_sequencer (
        .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr),
        .imem_rvalid(imem_rvalid), .imem_rdata(imem_rdata), .gr0_clr(gr0_clr),
        .wq_init(wq_init), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_word(iss_word), .iss_pc(iss_pc), .iss_first(iss_first),
        .iss_last(iss_last), .iss_slot(iss_slot), .media_vld(media_vld),
        .media_id(media_id), .commit_start(commit_start),
        .commit_done(commit_done), .commit_pc(commit_pc), .retired(retired)
    );

    // bench slot model: slot code carried in word bits 26:24
    assign iss_slot = iss_word[26:24];

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // instruction memory model with programmable latency
    logic [31:0] mem [0:255];
    int lat = 0;
    int mcnt = 0;
    always @(posedge clk) begin
        if (imem_req) begin
            if (mcnt >= lat) begin
                imem_rvalid <= 1'b1;
                imem_rdata  <= mem[imem_addr[9:2]];
                mcnt        <= 0;
            end else begin
                imem_rvalid <= 1'b0;
                mcnt        <= mcnt + 1;
            end
        end else begin
            imem_rvalid <= 1'b0;
            mcnt        <= 0;
        end
    end

    // execute-stage ready model
    bit stall_en = 1'b0;
    int rcnt = 0;
    always @(posedge clk) begin
        rcnt      <= rcnt + 1;
        iss_ready <= stall_en ? (rcnt % 3 == 2) : 1'b1;
    end

    // monitor
    logic [31:0] lpc [0:15];
    logic [31:0] lword [0:15];
    bit lfirst [0:15];
    bit llast [0:15];
    int ln = 0, gr0_n = 0, init_n = 0, cs_n = 0;
    bit gr0_pend = 1'b0;
    bit commit_seen = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (gr0_clr) begin
                gr0_n++;
                gr0_pend = 1'b1;
            end
            if (wq_init) init_n++;
            if (commit_start) begin
                cs_n++;
                commit_seen = 1'b1;
            end
            if (iss_valid && iss_ready) begin
                chk(gr0_pend, "R5 gr0 clear before issue", 0, 1);
                gr0_pend = 1'b0;
                if (ln < 16) begin
                    lpc[ln]    = iss_pc;
                    lword[ln]  = iss_word;
                    lfirst[ln] = iss_first;
                    llast[ln]  = iss_last;
                end
                ln++;
            end
        end
    end

    logic [31:0] exp_ret = 0;

    task automatic wait_commit();
        for (int k = 0; k < 3000 && !commit_seen; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_packet(input logic [31:0] base, input int exp_n,
                              input bit exp_mvld, input logic [1:0] exp_mid, input string tag);
        ln = 0; gr0_n = 0; init_n = 0; cs_n = 0; commit_seen = 1'b0;
        @(negedge clk);
        commit_done = 1'b1;
        commit_pc   = base;
        @(negedge clk);
        commit_done = 1'b0;
        wait_commit();
        exp_ret = exp_ret + exp_n;
        chk(ln == exp_n, {tag, " R2 R3 packet length"}, ln, exp_n);
        for (int i = 0; i < exp_n && i < ln; i++) begin
            chk(lpc[i] == base + 4 * i, {tag, " R1 pc"}, lpc[i], base + 4 * i);
            chk(lword[i] == mem[base[9:2] + i[7:0]], {tag, " R1 word"}, lword[i], mem[base[9:2] + i[7:0]]);
            chk(lfirst[i] == (i == 0), {tag, " R4 first flag"}, lfirst[i], (i == 0));
            chk(llast[i] == (i == exp_n - 1), {tag, " R2 R3 last flag"}, llast[i], (i == exp_n - 1));
        end
        chk(gr0_n == exp_n, {tag, " R5 gr0 pulse count"}, gr0_n, exp_n);
        chk(init_n == 1, {tag, " R6 queue init count"}, init_n, 1);
        chk(cs_n == 1, {tag, " R7 commit start count"}, cs_n, 1);
        chk(retired == exp_ret, {tag, " R8 retired total"}, retired, exp_ret);
        chk(media_vld == exp_mvld, {tag, " R9 media valid"}, media_vld, exp_mvld);
        if (exp_mvld)
            chk(media_id == exp_mid, {tag, " R9 media id"}, media_id, exp_mid);
    endtask

    task automatic t_end_bit_three();
        mem[8'h10] = 32'h0000_0011;
        mem[8'h11] = 32'h0000_0022;
        mem[8'h12] = 32'h8000_0033;
        mem[8'h13] = 32'h0000_0044;
        run_packet(32'h40, 3, 1'b0, 2'd0, "R2 end bit three");
    endtask

    task automatic t_size_limit();
        for (int i = 0; i < 10; i++) mem[8'h40 + i[7:0]] = 32'h0000_0100 + i;
        run_packet(32'h100, MAXP, 1'b0, 2'd0, "R3 size limit");
    endtask

    task automatic t_single();
        mem[8'h80] = 32'h8000_0abc;
        mem[8'h81] = 32'h0000_0def;
        run_packet(32'h200, 1, 1'b0, 2'd0, "R4 single word");
    endtask

    task automatic t_end_on_final_slot();
        for (int i = 0; i < 10; i++)
            mem[8'hc0 + i[7:0]] = (i == 7 ? 32'h8000_0000 : 32'h0) | (32'h300 + i);
        run_packet(32'h300, MAXP, 1'b0, 2'd0, "R3 end bit on final slot");
    endtask

    task automatic t_stalls();
        for (int i = 0; i < 4; i++)
            mem[8'he0 + i[7:0]] = (i == 3 ? 32'h8000_0000 : 32'h0) | (32'h0055_0000 + i);
        lat = 3;
        stall_en = 1'b1;
        run_packet(32'h380, 4, 1'b0, 2'd0, "R10 latency and stalls");
        lat = 0;
        stall_en = 1'b0;
    endtask

    task automatic t_media();
        mem[8'h20] = 32'h0500_0001; // media slot 1
        mem[8'h21] = 32'h0200_0002; // non-media code 2
        mem[8'h22] = 32'h8700_0003; // media slot 3, last
        run_packet(32'h80, 3, 1'b1, 2'd3, "R9 media latest");
        run_packet(32'h40, 3, 1'b0, 2'd0, "R9 media cleared");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[0] = 32'h8000_0000;
        rst = 1'b1;
        commit_done = 1'b0;
        commit_pc = 32'h0;
        imem_rvalid = 1'b0;
        imem_rdata = 32'h0;
        iss_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(retired == 0, "R11 reset retired", retired, 0);
        chk(!iss_valid && !commit_start && !imem_req, "R11 reset outputs",
            {iss_valid, commit_start, imem_req}, 0);
        rst = 1'b0;
        wait_commit();
        exp_ret = 1;
        chk(retired == 1, "R8 first packet at reset pc", retired, 1);
        t_end_bit_three();
        t_size_limit();
        t_single();
        t_end_on_final_slot();
        t_stalls();
        t_media();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule